// File: doc/BRIEF.md
# Two-Bank Edge-Event GPIO Controller

This block is a general-purpose I/O controller that sits behind a small byte-wide register window. Its pins are split into two banks, a low bank and a high bank, and each bank has the same set of eight per-pin registers. These cover pin enable, direction, drive and sampled level, separate rising and falling edge detection, an event mask, a plain routing-select byte and a sticky event status. Each pad is modelled as three separate signals: an input, an output value and an output enable.

Input pads are synchronised through two flops. An edge is found by comparing the synchronised value with the value it had one cycle earlier. When an enabled pin sees an edge that its rising or falling enable selects, its status bit is set and stays set until software writes a one to it. A single level-type event line is high whenever any status bit in either bank has its mask bit set. Software handles an event by reading the status bytes, servicing the pins and writing the set bits back to clear them.

The register byte address is split as follows. Bit 5 selects the bank (0 = low, 1 = high). Bits 4:2 select the register: 0 enable, 1 direction, 2 level, 3 rising enable, 4 falling enable, 5 event mask, 6 routing select, 7 status. Bits 1:0 select the byte lane: lane 0 holds pins 0–7 of the bank, lane 1 holds pins 8–15, and lanes 2 and 3 are empty.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, enable reads with only the lowest EN_RST_CNT pins of each bank set (0x07 for the default), direction reads 1 for every existing pin, status reads 0, `pad_oe` is all 0 and `event_irq` is 0.
- R2: A read strobe with address A returns the addressed byte on `bus_rdata` from the next clock edge on, and `bus_rdata` holds its value between reads. A write takes effect at the clock edge that samples the strobe.
- R3: Direction bit 1 means input and 0 means output. `pad_oe` of a pin is 1 exactly when its enable bit is 1 and its direction bit is 0. The direction register reads back the written value.
- R4: A write to the level register changes only the pins that are outputs, and the written value drives `pad_out`. Reading the level register returns the synchronised pad value for an input pin and the stored drive value for an output pin.
- R5: Rising and falling enables act independently per pin, and setting both catches either edge. Only enabled pins record edges. The status bit is readable from the third clock edge after the pad changes.
- R6: A status bit stays set until a 1 is written to it (register 7). Writing 0 leaves it unchanged.
- R7: When an edge and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R8: `event_irq` is the OR, over both banks, of status AND event mask. It follows changes to either operand with no extra delay after the register update.
- R9: Bits for pins that do not exist, and byte lanes 2 and 3, read as 0 and ignore writes.
- R10: High-bank pin n is pad CORE_PINS+n, and its events appear only in the high-bank status byte.
- R11: The routing-select register (6) is read/write storage for the existing pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_addr | input | 6 | Byte address: bank, register, lane |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | CORE_PINS+RESUME_PINS | Pad input levels |
| pad_out | output | CORE_PINS+RESUME_PINS | Pad drive values |
| pad_oe | output | CORE_PINS+RESUME_PINS | Pad output enables |
| event_irq | output | 1 | Level event request |

## Verification
Two functions can act on the same status bit in the same cycle: edge capture and the write-one-to-clear path. The bench sets a status bit, then changes that pad so that the detected edge is present exactly at the clock edge that samples the clearing write. It counts the flops in the synchroniser to place the write at that edge. It then reads the bit back and expects it still set, and a later plain clear with a quiet pad must empty it. It also checks that writing a level while the pin is an input, and writing to missing pins, leave the outputs and readback unchanged.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  typedef enum logic [2:0] {
    RG_ENABLE = 3'd0,
    RG_DIR    = 3'd1,
    RG_LEVEL  = 3'd2,
    RG_RISE   = 3'd3,
    RG_FALL   = 3'd4,
    RG_EVTEN  = 3'd5,
    RG_ROUTE  = 3'd6,
    RG_STATUS = 3'd7
  } gpio_reg_e;

  localparam int LANE_W    = 8;
  localparam int BANK_MAX  = 16;
endpackage

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_ctrl_pkg::*;
#(
  parameter int PINS       = 8,
  parameter int EN_RST_CNT = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  gpio_reg_e             reg_i,
  input  logic                  lane_i,
  input  logic [LANE_W-1:0]     wdata_i,
  output logic [LANE_W-1:0]     rdata_o,
  input  logic [BANK_MAX-1:0]   pad_in_i,
  output logic [BANK_MAX-1:0]   pad_out_o,
  output logic [BANK_MAX-1:0]   pad_oe_o,
  output logic                  pend_o
);
  localparam logic [BANK_MAX-1:0] PMASK  = BANK_MAX'((32'd1 << PINS) - 32'd1);
  localparam logic [BANK_MAX-1:0] EN_RST = BANK_MAX'((32'd1 << EN_RST_CNT) - 32'd1) & PMASK;

  logic [BANK_MAX-1:0] en_q, dir_q, lvl_q, rise_q, fall_q, ge_q, route_q, st_q;
  logic [BANK_MAX-1:0] sync_v, rise_v, fall_v;
  logic [BANK_MAX-1:0] wv, wmask, hit, clr, lvl_view, rview;

  gpio_edge_detect #(.W(BANK_MAX)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (pad_in_i),
    .sync_o (sync_v),
    .rise_o (rise_v),
    .fall_o (fall_v)
  );

  assign wv    = lane_i ? {wdata_i, 8'h00} : {8'h00, wdata_i};
  assign wmask = wr_i ? ((lane_i ? 16'hFF00 : 16'h00FF) & PMASK) : '0;
  assign hit   = en_q & ((rise_q & rise_v) | (fall_q & fall_v)) & PMASK;
  assign clr   = (reg_i == RG_STATUS) ? (wv & wmask) : '0;

  function automatic logic [BANK_MAX-1:0] merge(input logic [BANK_MAX-1:0] old_v,
                                                input logic [BANK_MAX-1:0] m);
    return (old_v & ~m) | (wv & m);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= EN_RST;
      dir_q   <= PMASK;
      lvl_q   <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      ge_q    <= '0;
      route_q <= '0;
      st_q    <= '0;
    end else begin
      case (reg_i)
        RG_ENABLE: en_q    <= merge(en_q, wmask);
        RG_DIR:    dir_q   <= merge(dir_q, wmask);
        RG_LEVEL:  lvl_q   <= merge(lvl_q, wmask & ~dir_q);
        RG_RISE:   rise_q  <= merge(rise_q, wmask);
        RG_FALL:   fall_q  <= merge(fall_q, wmask);
        RG_EVTEN:  ge_q    <= merge(ge_q, wmask);
        RG_ROUTE:  route_q <= merge(route_q, wmask);
        default:   ;
      endcase
      st_q <= (st_q & ~clr) | hit;
    end
  end

  assign lvl_view = ((dir_q & sync_v) | (~dir_q & lvl_q)) & PMASK;

  always_comb begin
    case (reg_i)
      RG_ENABLE: rview = en_q;
      RG_DIR:    rview = dir_q;
      RG_LEVEL:  rview = lvl_view;
      RG_RISE:   rview = rise_q;
      RG_FALL:   rview = fall_q;
      RG_EVTEN:  rview = ge_q;
      RG_ROUTE:  rview = route_q;
      default:   rview = st_q;
    endcase
  end

  assign rdata_o   = lane_i ? rview[15:8] : rview[7:0];
  assign pad_out_o = lvl_q;
  assign pad_oe_o  = en_q & ~dir_q;
  assign pend_o    = |(st_q & ge_q);
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int CORE_PINS   = 10,
  parameter int RESUME_PINS = 4,
  parameter int EN_RST_CNT  = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bus_wr,
  input  logic                              bus_rd,
  input  logic [5:0]                        bus_addr,
  input  logic [7:0]                        bus_wdata,
  output logic [7:0]                        bus_rdata,
  input  logic [CORE_PINS+RESUME_PINS-1:0]  pad_in,
  output logic [CORE_PINS+RESUME_PINS-1:0]  pad_out,
  output logic [CORE_PINS+RESUME_PINS-1:0]  pad_oe,
  output logic                              event_irq
);
  localparam int NP = CORE_PINS + RESUME_PINS;

  logic [1:0][BANK_MAX-1:0] pin16, out16, oe16;
  logic [1:0][LANE_W-1:0]   rd_b;
  logic [1:0]               pend_b;
  logic                     bank_sel, lane_ok;
  gpio_reg_e                reg_sel;
  logic [7:0]               rdata_q;

  assign bank_sel = bus_addr[5];
  assign lane_ok  = ~bus_addr[1];
  assign reg_sel  = gpio_reg_e'(bus_addr[4:2]);
  assign pin16[0] = BANK_MAX'(pad_in[CORE_PINS-1:0]);
  assign pin16[1] = BANK_MAX'(pad_in[NP-1:CORE_PINS]);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam int BP = (b == 0) ? CORE_PINS : RESUME_PINS;
    gpio_bank #(.PINS(BP), .EN_RST_CNT(EN_RST_CNT)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (bus_wr && lane_ok && (bank_sel == 1'(b))),
      .reg_i     (reg_sel),
      .lane_i    (bus_addr[0]),
      .wdata_i   (bus_wdata),
      .rdata_o   (rd_b[b]),
      .pad_in_i  (pin16[b]),
      .pad_out_o (out16[b]),
      .pad_oe_o  (oe16[b]),
      .pend_o    (pend_b[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= lane_ok ? rd_b[bank_sel] : 8'h00;
  end

  assign bus_rdata = rdata_q;
  assign pad_out   = {out16[1][RESUME_PINS-1:0], out16[0][CORE_PINS-1:0]};
  assign pad_oe    = {oe16[1][RESUME_PINS-1:0], oe16[0][CORE_PINS-1:0]};
  assign event_irq = |pend_b;
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
  parameter int NP = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [7:0]    bus_rdata,
  input logic [NP-1:0] pad_out,
  input logic [NP-1:0] pad_oe,
  input logic          event_irq
);
  // R2: read data only moves after a read strobe
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_rdata) |-> $past(bus_rd));

  // R3: output enables only change after a register write
  p_oe_by_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pad_oe) |-> $past(bus_wr));

  // R4: drive values only change after a register write
  p_out_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pad_out) |-> $past(bus_wr));

  // R6: the event line only drops after a write (clear or mask change)
  p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(event_irq) |-> $past(bus_wr));
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NP(CORE_PINS + RESUME_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .event_irq (event_irq)
);

// File: tb/gpio_ctrl_test.sv
module gpio_ctrl_test;
  localparam int CP = 10;
  localparam int RP = 4;
  localparam int NP = CP + RP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]    bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [NP-1:0] pads = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic          event_irq;
  int            n_checks = 0;
  int            n_errors = 0;

  always #10 clk = ~clk;

  gpio_ctrl #(.CORE_PINS(CP), .RESUME_PINS(RP), .EN_RST_CNT(3)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pads), .pad_out(pad_out), .pad_oe(pad_oe), .event_irq(event_irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_pads(input logic [NP-1:0] v);
    @(negedge clk);
    pads = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(6'h00, d); check("R1 enable lane0", d, 8'h07);
    rd(6'h01, d); check("R1 enable lane1", d, 8'h00);
    rd(6'h04, d); check("R1 dir lane0", d, 8'hFF);
    rd(6'h05, d); check("R1 R9 dir lane1", d, 8'h03);
    rd(6'h24, d); check("R1 dir high bank", d, 8'h0F);
    rd(6'h1C, d); check("R1 status", d, 8'h00);
    check("R1 pad_oe", pad_oe, 0);
    check("R1 event_irq", event_irq, 0);
  endtask

  task automatic t_direction();
    logic [7:0] d;
    wr(6'h00, 8'h17);
    wr(6'h04, 8'hEF);
    check("R3 pad_oe pin4", pad_oe, 14'h0010);
    rd(6'h04, d); check("R3 dir readback", d, 8'hEF);
  endtask

  task automatic t_level();
    logic [7:0] d;
    wr(6'h08, 8'hFF);
    check("R4 only output drives", pad_out, 14'h0010);
    set_pads(14'h0081);
    rd(6'h08, d); check("R4 level view", d, 8'h91);
    set_pads(14'h0000);
    wr(6'h08, 8'h00);
    check("R4 output level cleared", pad_out, 14'h0000);
  endtask

  task automatic t_edges();
    logic [7:0] d;
    wr(6'h0C, 8'h0D);
    wr(6'h10, 8'h06);
    set_pads(14'h000F);
    rd(6'h1C, d); check("R5 rising only where enabled", d, 8'h05);
    set_pads(14'h0000);
    rd(6'h1C, d); check("R5 falling added", d, 8'h07);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    wr(6'h1C, 8'h00);
    rd(6'h1C, d); check("R6 zero write keeps", d, 8'h07);
    wr(6'h1C, 8'h02);
    rd(6'h1C, d); check("R6 single clear", d, 8'h05);
    wr(6'h1C, 8'h05);
    rd(6'h1C, d); check("R6 all cleared", d, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    set_pads(14'h0001);
    check("R8 masked no irq", event_irq, 0);
    wr(6'h14, 8'h01);
    check("R8 mask on irq", event_irq, 1);
    wr(6'h1C, 8'h01);
    check("R8 clear drops irq", event_irq, 0);
    set_pads(14'h0000);
    wr(6'h2C, 8'h01);
    wr(6'h34, 8'h01);
    set_pads(14'h0400);
    check("R10 R8 high bank irq", event_irq, 1);
    rd(6'h3C, d); check("R10 high status", d, 8'h01);
    rd(6'h1C, d); check("R10 low status clean", d, 8'h00);
    wr(6'h3C, 8'h01);
    check("R10 high clear", event_irq, 0);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    set_pads(14'h0404);
    rd(6'h1C, d); check("R7 setup", d, 8'h04);
    @(negedge clk); pads = 14'h0400;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 6'h1C; bus_wdata = 8'h04;
    @(negedge clk); bus_wr = 1'b0;
    rd(6'h1C, d); check("R7 edge beats clear", d, 8'h04);
    wr(6'h1C, 8'h04);
    rd(6'h1C, d); check("R7 later clear", d, 8'h00);
  endtask

  task automatic t_unused();
    logic [7:0] d;
    wr(6'h20, 8'hFF);
    rd(6'h20, d); check("R9 high enable masked", d, 8'h0F);
    wr(6'h05, 8'hFF);
    rd(6'h05, d); check("R9 dir lane1 masked", d, 8'h03);
    wr(6'h02, 8'hFF);
    rd(6'h02, d); check("R9 lane2 zero", d, 8'h00);
    rd(6'h00, d); check("R9 lane2 write ignored", d, 8'h17);
    wr(6'h18, 8'hA5);
    rd(6'h18, d); check("R11 route store", d, 8'hA5);
    wr(6'h19, 8'hFF);
    rd(6'h19, d); check("R11 route lane1", d, 8'h03);
    rd(6'h00, d);
    @(negedge clk);
    check("R2 rdata holds", bus_rdata, 8'h17);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direction();
        t_level();
        t_edges();
        t_w1c();
        t_irq();
        t_collide();
        t_unused();
      end
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule